// File: doc/BRIEF.md
# Tower Energy Sum Pipeline

This block is the energy front end of a calorimeter trigger processor. Each clock it accepts a fixed number of detector channels. Every channel carries two energy words, one electromagnetic and one hadronic, and each word has its own parity bit. The block drops words that fail the parity check and removes masked channels. It then forms one tower value per channel from the two energies and discards towers below a programmable floor. The surviving towers are reduced to a single total transverse energy, which clamps at its largest code instead of wrapping.

The datapath is a fixed chain of registered stages:

- an input register;
- a parity and mask stage;
- a presum stage;
- a threshold stage;
- a pipelined adder tree with one adder level per register.

A valid flag travels alongside the data, so every result emerges a fixed number of cycles after its input. Parity failures also set a sticky error flag for the channel. Control logic clears that flag with a one-cycle clear pulse.

Top module: `tower_esum_pipe`

## Requirements
- R1: A word is accepted only when its data bits and its parity bit together hold an odd number of ones. If either word of an unmasked channel fails this check, the whole channel contributes zero to that cycle's total.
- R2: A parity failure on an unmasked channel during a valid cycle sets that channel's `par_err` bit two rising edges after the input is presented. The bit stays set until an `err_clr` pulse for that channel. When a set and a clear reach the same edge, the set wins.
- R3: A channel whose `chan_mask` bit is 1 contributes zero to the total and never raises its parity error flag.
- R4: The tower value of a channel is the sum of its electromagnetic and hadronic values. It is VW+1 bits wide and is formed before any threshold is applied.
- R5: A tower value is kept when it is greater than or equal to `low_thr`; otherwise it contributes zero. With `low_thr` equal to 0, every tower is kept.
- R6: `sum_out` is the sum of the kept towers, limited to 2^TW-1. `sum_ovf` is 1 exactly when the unlimited sum exceeds 2^TW-1, and in that case `sum_out` is 2^TW-1.
- R7: Results appear 4+log2(NCH) rising edges after the input is presented (7 for eight channels). `out_valid` repeats `in_valid` with that delay. For a cycle that was not valid, `sum_out` and `sum_ovf` are 0.
- R8: After reset, `sum_out`, `sum_ovf`, `out_valid` and every `par_err` bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input channel words are valid this cycle |
| em_data | input | NCH*VW | Electromagnetic values; channel c at bits c*VW upward |
| em_par | input | NCH | Odd parity bit for each electromagnetic word |
| had_data | input | NCH*VW | Hadronic values; channel c at bits c*VW upward |
| had_par | input | NCH | Odd parity bit for each hadronic word |
| chan_mask | input | NCH | 1 removes the channel from the computation |
| low_thr | input | VW+1 | Minimum tower value that is kept |
| err_clr | input | NCH | One-cycle pulse that clears a channel's error flag |
| sum_out | output | TW | Saturated total energy |
| sum_ovf | output | 1 | Total was clamped at the maximum code |
| out_valid | output | 1 | `sum_out` belongs to a valid input cycle |
| par_err | output | NCH | Sticky parity error flag for each channel |

## Verification
Each stage register holds a contribution for one cycle only, so a corrupted tower or tree node appears as a wrong `sum_out` exactly 4+log2(NCH) edges after the input that fed it. A lost or duplicated valid bit shows as `out_valid` one cycle early or late. A saturation flag dropped inside the tree appears as a wrapped total without `sum_ovf`. The error flags are observed two edges after the offending input and again after each clear, so a missed set or a non-sticky flag is caught within a few cycles.

// File: rtl/tep_pkg.sv
package tep_pkg;
   // registers ahead of the adder tree: input, parity/mask, presum, threshold
   localparam int FRONT_STAGES = 4;

   function automatic int tree_levels(input int n);
      return $clog2(n);
   endfunction

   function automatic int total_latency(input int n);
      return FRONT_STAGES + $clog2(n);
   endfunction
endpackage

// File: rtl/tep_chan_front.sv
module tep_chan_front #(
   parameter int VW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld,
   input  logic [VW-1:0] em,
   input  logic          em_p,
   input  logic [VW-1:0] had,
   input  logic          had_p,
   input  logic          msk,
   input  logic [VW:0]   thr,
   input  logic          clr,
   output logic [VW:0]   tower,
   output logic          err
);
   logic          em_ok, had_ok, keep;
   logic [VW-1:0] em_q, had_q;
   logic [VW:0]   pre_q;

   // odd parity over data and parity bit together
   assign em_ok  = ^{em, em_p};
   assign had_ok = ^{had, had_p};
   assign keep   = vld && !msk && em_ok && had_ok;

   // stage: parity and mask
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         em_q  <= '0;
         had_q <= '0;
         err   <= 1'b0;
      end else begin
         em_q  <= keep ? em  : '0;
         had_q <= keep ? had : '0;
         if (vld && !msk && !(em_ok && had_ok))
            err <= 1'b1;
         else if (clr)
            err <= 1'b0;
      end
   end

   // stage: presum, then threshold cut
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         tower <= '0;
      end else begin
         pre_q <= {1'b0, em_q} + {1'b0, had_q};
         tower <= (pre_q >= thr) ? pre_q : '0;
      end
   end

   p_mask_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && msk) |=> (em_q == '0 && had_q == '0));
   p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !clr) |=> err);
   p_cut_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tower != '0) |-> ($past(pre_q) >= $past(thr)));
endmodule

// File: rtl/tep_sat_tree.sv
module tep_sat_tree #(
   parameter int NCH = 8,
   parameter int IW  = 9,
   parameter int TW  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH*IW-1:0] leaves,
   output logic [TW-1:0]     sum_o,
   output logic              ovf_o
);
   localparam logic [TW-1:0] MAXV = {TW{1'b1}};

   // heap numbering: node 1 is the root, nodes NCH..2*NCH-1 are leaves
   for (genvar i = 1; i < 2*NCH; i++) begin : g_n
      logic [TW-1:0] v;
      logic          s;
      if (i >= NCH) begin : g_leaf
         assign v = TW'(leaves[(i-NCH)*IW +: IW]);
         assign s = 1'b0;
      end else begin : g_add
         logic [TW:0] raw;
         assign raw = {1'b0, g_n[2*i].v} + {1'b0, g_n[2*i+1].v};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v <= '0;
               s <= 1'b0;
            end else if (g_n[2*i].s || g_n[2*i+1].s || raw[TW]) begin
               v <= MAXV;
               s <= 1'b1;
            end else begin
               v <= raw[TW-1:0];
               s <= 1'b0;
            end
         end
         p_sat_prop_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (g_n[2*i].s || g_n[2*i+1].s) |=> s);
      end
   end

   assign sum_o = g_n[1].v;
   assign ovf_o = g_n[1].s;
endmodule

// File: rtl/tower_esum_pipe.sv
module tower_esum_pipe #(
   parameter int NCH = 8,
   parameter int VW  = 8,
   parameter int TW  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [NCH*VW-1:0] em_data,
   input  logic [NCH-1:0]    em_par,
   input  logic [NCH*VW-1:0] had_data,
   input  logic [NCH-1:0]    had_par,
   input  logic [NCH-1:0]    chan_mask,
   input  logic [VW:0]       low_thr,
   input  logic [NCH-1:0]    err_clr,
   output logic [TW-1:0]     sum_out,
   output logic              sum_ovf,
   output logic              out_valid,
   output logic [NCH-1:0]    par_err
);
   import tep_pkg::*;

   localparam int IW  = VW + 1;
   localparam int LAT = total_latency(NCH);
   localparam int CW  = $clog2(LAT + 1);
   localparam logic [TW-1:0] MAXV = {TW{1'b1}};

   if (NCH < 2 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
      $error("NCH must be a power of two, at least 2");
   end
   if (TW < IW) begin : g_bad_tw
      $error("TW must hold at least one tower value");
   end

   // input register
   logic [NCH*VW-1:0] em_q, had_q;
   logic [NCH-1:0]    emp_q, hadp_q, msk_q;
   logic              v_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         em_q   <= '0;
         had_q  <= '0;
         emp_q  <= '0;
         hadp_q <= '0;
         msk_q  <= '0;
         v_q    <= 1'b0;
      end else begin
         em_q   <= em_data;
         had_q  <= had_data;
         emp_q  <= em_par;
         hadp_q <= had_par;
         msk_q  <= chan_mask;
         v_q    <= in_valid;
      end
   end

   logic [NCH*IW-1:0] towers;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      tep_chan_front #(.VW(VW)) u_front (
         .clk   (clk),
         .rst_n (rst_n),
         .vld   (v_q),
         .em    (em_q[c*VW +: VW]),
         .em_p  (emp_q[c]),
         .had   (had_q[c*VW +: VW]),
         .had_p (hadp_q[c]),
         .msk   (msk_q[c]),
         .thr   (low_thr),
         .clr   (err_clr[c]),
         .tower (towers[c*IW +: IW]),
         .err   (par_err[c])
      );
   end

   tep_sat_tree #(.NCH(NCH), .IW(IW), .TW(TW)) u_tree (
      .clk    (clk),
      .rst_n  (rst_n),
      .leaves (towers),
      .sum_o  (sum_out),
      .ovf_o  (sum_ovf)
   );

   // valid pipe: slot 0 is the input register
   logic [LAT-1:0] vpipe;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vpipe <= '0;
      else        vpipe <= {vpipe[LAT-2:0], in_valid};
   end
   assign out_valid = vpipe[LAT-1];

   // cycles since reset, for the latency check
   logic [CW-1:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   warm <= '0;
      else if (warm != CW'(LAT))    warm <= warm + 1'b1;
   end

   p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == CW'(LAT)) |-> (out_valid == $past(in_valid, LAT)));
   p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (sum_out == '0 && !sum_ovf));
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sum_ovf |-> (sum_out == MAXV));
endmodule

// File: tb/sim_tower_esum_pipe.sv
module sim_tower_esum_pipe;
   localparam int NCH  = 8;
   localparam int VW   = 8;
   localparam int TW   = 10;
   localparam int MAXV = 1023;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [NCH*VW-1:0] em_data = '0, had_data = '0;
   logic [NCH-1:0]    em_par = '0, had_par = '0, chan_mask = '0, err_clr = '0;
   logic [VW:0]       low_thr = '0;
   logic [TW-1:0]     sum_out;
   logic              sum_ovf, out_valid;
   logic [NCH-1:0]    par_err;

   tower_esum_pipe #(.NCH(NCH), .VW(VW), .TW(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .em_data(em_data), .em_par(em_par), .had_data(had_data), .had_par(had_par),
      .chan_mask(chan_mask), .low_thr(low_thr), .err_clr(err_clr),
      .sum_out(sum_out), .sum_ovf(sum_ovf), .out_valid(out_valid), .par_err(par_err)
   );

   always #5 clk = ~clk;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   logic [31:0] seed = 32'h1234_5677;
   logic [NCH-1:0] exp_err = '0;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] nxt();
      seed = seed * 32'd1664525 + 32'd1013904223;
      return seed;
   endfunction

   // drive one vector; eb/hb pick words sent with wrong parity
   task automatic drive(input logic [NCH*VW-1:0] e, input logic [NCH*VW-1:0] h,
                        input logic [NCH-1:0] eb, input logic [NCH-1:0] hb,
                        input logic [NCH-1:0] m);
      em_data = e; had_data = h; chan_mask = m; in_valid = 1'b1;
      for (int c = 0; c < NCH; c++) begin
         em_par[c]  = ~(^e[c*VW +: VW]) ^ eb[c];
         had_par[c] = ~(^h[c*VW +: VW]) ^ hb[c];
      end
   endtask

   task automatic model(input logic [NCH*VW-1:0] e, input logic [NCH*VW-1:0] h,
                        input logic [NCH-1:0] eb, input logic [NCH-1:0] hb,
                        input logic [NCH-1:0] m, input int th,
                        output int s, output int o);
      int tot = 0;
      for (int c = 0; c < NCH; c++) begin
         int t;
         t = int'(e[c*VW +: VW]) + int'(h[c*VW +: VW]);
         if (!m[c] && !eb[c] && !hb[c] && t >= th) tot += t;
      end
      o = (tot > MAXV) ? 1 : 0;
      s = (tot > MAXV) ? MAXV : tot;
   endtask

   // called at a negedge; returns at a negedge with inputs idle
   task automatic run_one(input logic [NCH*VW-1:0] e, input logic [NCH*VW-1:0] h,
                          input logic [NCH-1:0] eb, input logic [NCH-1:0] hb,
                          input logic [NCH-1:0] m, input int th, input string tag);
      int s, o;
      model(e, h, eb, hb, m, th, s, o);
      low_thr = (VW+1)'(th);
      drive(e, h, eb, hb, m);
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk({tag, " R7 not early"}, int'(out_valid), 0);
      @(posedge clk); @(negedge clk);
      chk({tag, " R7 valid"}, int'(out_valid), 1);
      chk({tag, " R6 sum"}, int'(sum_out), s);
      chk({tag, " R6 ovf"}, int'(sum_ovf), o);
      exp_err |= (eb | hb) & ~m;
      chk({tag, " R2 flags"}, int'(par_err), int'(exp_err));
      err_clr = '1;
      @(posedge clk); @(negedge clk);
      err_clr = '0;
      exp_err = '0;
      chk({tag, " R2 cleared"}, int'(par_err), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog R7 actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [NCH*VW-1:0] e, h;
      logic [NCH-1:0] eb, hb, m;
      int exp_s [12];
      int exp_o [12];
      int ths [7] = '{0, 1, 100, 255, 300, 510, 511};

      repeat (3) @(negedge clk);
      chk("R8 sum", int'(sum_out), 0);
      chk("R8 ovf", int'(sum_ovf), 0);
      chk("R8 valid", int'(out_valid), 0);
      chk("R8 flags", int'(par_err), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 presum: one channel, values split across the two words
      run_one(64'h0000_0000_0000_0011, 64'h0000_0000_0000_0022, '0, '0, '0, 0, "R4 single");
      run_one({8{8'd255}}, {8{8'd0}}, '0, '0, '0, 0, "R4 em only");
      // R6 saturation: every tower at 510
      run_one({8{8'd255}}, {8{8'd255}}, '0, '0, '0, 0, "R6 full");
      // R6 just below and just above the limit: 7*146=1022, then 1022+2
      run_one({8'd0, {7{8'd73}}}, {8'd0, {7{8'd73}}}, '0, '0, '0, 0, "R6 edge low");
      run_one({8'd1, {7{8'd73}}}, {8'd1, {7{8'd73}}}, '0, '0, '0, 0, "R6 edge high");
      // R3 masked channel with bad parity raises nothing
      run_one({8{8'd10}}, {8{8'd10}}, 8'h01, 8'h00, 8'h81, 0, "R3 mask");
      // R1 bad parity on hadronic word only
      run_one({8{8'd10}}, {8{8'd10}}, 8'h00, 8'h10, 8'h00, 0, "R1 had bad");
      // R5 threshold exactly at tower value keeps it, one above cuts it
      run_one({8{8'd50}}, {8{8'd50}}, '0, '0, '0, 100, "R5 equal");
      run_one({8{8'd50}}, {8{8'd50}}, '0, '0, '0, 101, "R5 above");

      // R2 timing and set-beats-clear
      low_thr = '0;
      drive('0, '0, 8'h04, 8'h00, '0);
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
      chk("R2 not after one edge", int'(par_err), 0);
      err_clr = 8'h04;
      @(posedge clk); @(negedge clk);
      chk("R2 set wins over clear", int'(par_err), 4);
      @(posedge clk); @(negedge clk);
      err_clr = '0;
      chk("R2 clear pulse", int'(par_err), 0);
      drive('0, '0, 8'h08, 8'h00, '0);
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R2 sticky", int'(par_err), 8);
      err_clr = '1;
      @(posedge clk); @(negedge clk);
      err_clr = '0;
      repeat (8) @(negedge clk);

      // sweep thresholds with pseudo-random traffic (R1 R3 R4 R5 R6)
      foreach (ths[k]) begin
         for (int n = 0; n < 30; n++) begin
            e = {nxt(), nxt()};
            h = {nxt(), nxt()};
            eb = ((n % 3) == 0) ? nxt()[7:0] & nxt()[7:0] : '0;
            hb = ((n % 4) == 1) ? nxt()[7:0] & nxt()[7:0] : '0;
            m  = ((n % 2) == 0) ? nxt()[15:8] & nxt()[15:8] : '0;
            run_one(e, h, eb, hb, m, ths[k], "sweep");
         end
      end

      // R7 back-to-back stream with a gap at vector 5
      low_thr = 9'd20;
      for (int j = 0; j < 19; j++) begin
         if (j >= 7) begin
            if (j - 7 == 5) begin
               chk("R7 stream gap valid", int'(out_valid), 0);
               chk("R7 stream gap sum", int'(sum_out), 0);
            end else begin
               chk("R7 stream valid", int'(out_valid), 1);
               chk("R7 stream sum", int'(sum_out), exp_s[j-7]);
               chk("R6 stream ovf", int'(sum_ovf), exp_o[j-7]);
            end
         end
         if (j < 12) begin
            e = {nxt(), nxt()};
            h = {nxt(), nxt()};
            model(e, h, '0, '0, '0, 20, exp_s[j], exp_o[j]);
            drive(e, h, '0, '0, '0);
            if (j == 5) in_valid = 1'b0;
         end else begin
            in_valid = 1'b0;
         end
         @(posedge clk); @(negedge clk);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule